// File: doc/BRIEF.md
# Accumulating Bus Fault Status Register

This block keeps a sticky record of why processor bus cycles failed. Each time a bus cycle completes, the block looks at the fault indicators that came with it: missing page mapping, protection violation, access timeout, external bus error and access-size error. It merges every qualified fault into an 8-bit status byte. Several cycles can fault in a row, as happens with instruction prefetch. The byte then shows the union of all causes, and software separates them by other means. Cycles started by a DMA master never touch the byte.

A watchdog-reset event leaves a mark of its own in the lowest bit. The processor reads the byte through a single register in the control address space. The register cannot be written. A completed read returns the byte one clock later in the low byte of the data bus and empties the register. Any fault that lands in the same cycle as that read is still kept.

Top module: `bus_fault_status`

## Requirements
- R1: Status bit layout: bit 7 = page mapping invalid, bit 6 = protection violation, bit 5 = access timeout, bit 4 = external bus error, bit 1 = access-size error, bit 0 = watchdog reset. Bits 3 and 2 always read 0.
- R2: A qualified fault sets its bit by OR into the current byte. No fault clears a bit that is already set, so several causes can be flagged together.
- R3: A completing cycle with `cyc_is_dma` high leaves the status unchanged, whatever fault indicators it carries.
- R4: The protection bit is set only when `flt_prot` is high and `flt_nomap` is low. A cycle carrying both sets only bit 7.
- R5: A write access to the register address does not change the status and returns no read data.
- R6: The register is selected only by a read with `acc_space` equal to `CTL_SPACE` (default 4'h2) and `acc_addr` equal to `REG_ADDR` (default 32'h6000_0000). Any other space or address gives no `rd_valid` and does not clear the status.
- R7: A selecting read clears every status bit at the next clock edge. The bits of a qualified fault in that same cycle remain set after the edge.
- R8: `wdog_evt` sets the status to exactly 8'h01 at the next edge, discarding all other bits and winning over a simultaneous fault or read. A synchronous active-low `rst_n` clears all bits, bit 0 included.
- R9: Fault indicators are ignored in any cycle where `cyc_done` is low.
- R10: One clock after a selecting read, `rd_valid` is high for one cycle. `rd_data` then carries the status value from before that read, zero-extended to 32 bits. Otherwise `rd_valid` is low and `rd_data` is zero.
- R11: After reset, `rd_valid` is low and a read returns 32'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cyc_done | input | 1 | Bus cycle completes this clock; fault inputs are valid |
| cyc_is_dma | input | 1 | Completing cycle was started by a DMA master |
| flt_nomap | input | 1 | Page mapping entry was not valid |
| flt_prot | input | 1 | Access type not permitted by the page |
| flt_tmo | input | 1 | Bus access timed out |
| flt_extbus | input | 1 | External bus reported an error |
| flt_size | input | 1 | Access size not supported |
| wdog_evt | input | 1 | Watchdog reset event |
| acc_valid | input | 1 | Processor register access this clock |
| acc_write | input | 1 | Access is a write |
| acc_space | input | 4 | Address space code of the access |
| acc_addr | input | 32 | Address of the access |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, status byte in bits 7:0 |

## Verification
The clearing read and the capture of a new fault can fall in the same cycle. The bench provokes this by driving a selecting read together with a completing processor cycle that carries a timeout or size fault. It then checks two results: the read returns the byte as it stood before the edge, and a second read returns only the new fault's bits. A second collision is a watchdog event together with a fault and a read. In that case the following read must return exactly 8'h01. A reference model, advanced once per clock, judges every returned word.

// File: rtl/bus_fault_pkg.sv
// Package: shared widths, bit positions and types for the bus fault
// status register. Assumes an 8-bit status byte; bit positions are fixed
// because software decodes them.
package bus_fault_pkg;
    localparam int STAT_W    = 8;
    localparam int BIT_NOMAP = 7;
    localparam int BIT_PROT  = 6;
    localparam int BIT_TMO   = 5;
    localparam int BIT_EXT   = 4;
    localparam int BIT_SIZE  = 1;
    localparam int BIT_WDOG  = 0;

    typedef logic [STAT_W-1:0] stat_t;

    // Per-cycle fault indicators as delivered by the bus logic.
    typedef struct packed {
        logic nomap;
        logic prot;
        logic tmo;
        logic extbus;
        logic size;
    } fault_t;

    // Bits that exist in the register; the rest always read zero.
    localparam stat_t IMPL_MASK = (stat_t'(1) << BIT_NOMAP) | (stat_t'(1) << BIT_PROT)
                                | (stat_t'(1) << BIT_TMO)   | (stat_t'(1) << BIT_EXT)
                                | (stat_t'(1) << BIT_SIZE)  | (stat_t'(1) << BIT_WDOG);
    localparam stat_t WDOG_ONLY = stat_t'(1) << BIT_WDOG;
endpackage

// File: rtl/fault_qualify.sv
// Module: fault_qualify
// Turns the raw fault indicators of one completing bus cycle into a mask
// of status bits to set. Assumes the indicators are valid only while
// cyc_done is high. DMA cycles produce an empty mask. Protection is
// reported only when the page mapping was valid.
module fault_qualify
    import bus_fault_pkg::*;
(
    input  logic   cyc_done,
    input  logic   cyc_is_dma,
    input  fault_t faults,
    output stat_t  set_mask
);
    logic take;

    // Purpose: a cycle counts only when it completes and the processor started it.
    assign take = cyc_done && !cyc_is_dma;

    // Purpose: map the qualified indicators onto their status bit positions.
    always_comb begin
        set_mask = '0;
        if (take) begin
            set_mask[BIT_NOMAP] = faults.nomap;
            set_mask[BIT_PROT]  = faults.prot && !faults.nomap;
            set_mask[BIT_TMO]   = faults.tmo;
            set_mask[BIT_EXT]   = faults.extbus;
            set_mask[BIT_SIZE]  = faults.size;
        end
    end
endmodule

// File: rtl/ctl_decode.sv
// Module: ctl_decode
// Decides whether the current processor access is a read of the status
// register. Assumes acc_* are valid while acc_valid is high. Writes never
// select, because the register is read-only.
module ctl_decode #(
    parameter int             ADDR_W    = 32,
    parameter int             SPACE_W   = 4,
    parameter logic [SPACE_W-1:0] CTL_SPACE = 4'h2,
    parameter logic [ADDR_W-1:0]  REG_ADDR  = 32'h6000_0000
) (
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [SPACE_W-1:0] acc_space,
    input  logic [ADDR_W-1:0]  acc_addr,
    output logic               rd_sel
);
    logic space_hit;
    logic addr_hit;

    // Purpose: compare space and address against the register's location.
    assign space_hit = (acc_space == CTL_SPACE);
    assign addr_hit  = (acc_addr == REG_ADDR);

    // Purpose: only a read access at the exact location selects the register.
    assign rd_sel = acc_valid && !acc_write && space_hit && addr_hit;
endmodule

// File: rtl/fault_accum.sv
// Module: fault_accum
// Holds the sticky status byte. New fault bits OR in. A selecting read
// empties the byte at the same edge that captures any new fault. A
// watchdog event replaces everything with the watchdog bit alone. Assumes
// a synchronous active-low reset.
module fault_accum
    import bus_fault_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t set_mask,
    input  logic  clr_req,
    input  logic  wdog_evt,
    output stat_t status
);
    stat_t kept;
    stat_t next_status;

    // Purpose: drop the old contents when the register is being read.
    assign kept = clr_req ? stat_t'(0) : status;

    // Purpose: pick the next value; the watchdog event overrides all else.
    always_comb begin
        if (wdog_evt)
            next_status = WDOG_ONLY;
        else
            next_status = (kept | set_mask) & IMPL_MASK;
    end

    // Purpose: the status register itself.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= next_status;
    end
endmodule

// File: rtl/status_read_port.sv
// Module: status_read_port
// Registers the read response: one clock after a selecting read it shows
// the status byte as it was before the clearing edge, zero-extended to
// the data bus. Assumes DATA_W >= STAT_W.
module status_read_port
    import bus_fault_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel,
    input  stat_t             status,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - STAT_W;

    logic [DATA_W-1:0] word;

    // Purpose: place the status byte in the low bits of a bus word.
    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, status};
        end else begin : g_nopad
            assign word = status[DATA_W-1:0];
        end
    endgenerate

    // Purpose: return the data one clock after the select and keep the bus quiet otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_sel;
            rd_data  <= rd_sel ? word : '0;
        end
    end
endmodule

// File: rtl/bus_fault_status.sv
// Module: bus_fault_status (top)
// Sticky record of processor bus cycle faults, read (and thereby cleared)
// through one register in the control address space. Assumes all inputs
// are synchronous to clk and that the reset is synchronous active-low.
module bus_fault_status
    import bus_fault_pkg::*;
#(
    parameter int                 ADDR_W    = 32,
    parameter int                 DATA_W    = 32,
    parameter int                 SPACE_W   = 4,
    parameter logic [SPACE_W-1:0] CTL_SPACE = 4'h2,
    parameter logic [ADDR_W-1:0]  REG_ADDR  = 32'h6000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_done,
    input  logic               cyc_is_dma,
    input  logic               flt_nomap,
    input  logic               flt_prot,
    input  logic               flt_tmo,
    input  logic               flt_extbus,
    input  logic               flt_size,
    input  logic               wdog_evt,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [SPACE_W-1:0] acc_space,
    input  logic [ADDR_W-1:0]  acc_addr,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data
);
    fault_t faults;
    stat_t  set_mask;
    stat_t  status_q;
    logic   rd_sel;

    // Purpose: gather the loose fault pins into one bundle.
    assign faults = '{nomap: flt_nomap, prot: flt_prot, tmo: flt_tmo,
                      extbus: flt_extbus, size: flt_size};

    fault_qualify u_qual (
        .cyc_done   (cyc_done),
        .cyc_is_dma (cyc_is_dma),
        .faults     (faults),
        .set_mask   (set_mask)
    );

    ctl_decode #(
        .ADDR_W    (ADDR_W),
        .SPACE_W   (SPACE_W),
        .CTL_SPACE (CTL_SPACE),
        .REG_ADDR  (REG_ADDR)
    ) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_space (acc_space),
        .acc_addr  (acc_addr),
        .rd_sel    (rd_sel)
    );

    fault_accum u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_req  (rd_sel),
        .wdog_evt (wdog_evt),
        .status   (status_q)
    );

    status_read_port #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (rd_sel),
        .status   (status_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/bus_fault_status_chk.sv
// Module: bus_fault_status_chk
// Property checker for bus_fault_status, attached with bind. It observes
// the ports and the internal status byte.
module bus_fault_status_chk #(
    parameter int                 ADDR_W    = 32,
    parameter int                 DATA_W    = 32,
    parameter int                 SPACE_W   = 4,
    parameter logic [SPACE_W-1:0] CTL_SPACE = 4'h2,
    parameter logic [ADDR_W-1:0]  REG_ADDR  = 32'h6000_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cyc_done,
    input logic               cyc_is_dma,
    input logic               flt_nomap,
    input logic               wdog_evt,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [SPACE_W-1:0] acc_space,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic               rd_valid,
    input logic [DATA_W-1:0]  rd_data,
    input logic [7:0]         status
);
    logic sel;

    // Purpose: the checker's own view of a selecting read, from the ports.
    assign sel = acc_valid && !acc_write && (acc_space == CTL_SPACE) && (acc_addr == REG_ADDR);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[DATA_W-1:8] == '0) && (rd_data[3:2] == 2'b00));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdog_evt && !sel) |=> ((status & $past(status)) == $past(status)));

    assert_dma_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && cyc_is_dma && !wdog_evt && !sel) |=> $stable(status));

    assert_prot_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !cyc_is_dma && flt_nomap && !wdog_evt && (sel || !status[6]))
        |=> !status[6]);

    assert_wdog_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_evt |=> (status == 8'h01));

    assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_done && !wdog_evt && !sel) |=> $stable(status));

    assert_read_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> (rd_valid && (rd_data[7:0] == $past(status))));

    assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!rd_valid && (rd_data == '0)));
endmodule

bind bus_fault_status bus_fault_status_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SPACE_W   (SPACE_W),
    .CTL_SPACE (CTL_SPACE),
    .REG_ADDR  (REG_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_done   (cyc_done),
    .cyc_is_dma (cyc_is_dma),
    .flt_nomap  (flt_nomap),
    .wdog_evt   (wdog_evt),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_space  (acc_space),
    .acc_addr   (acc_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .status     (status_q)
);

// File: tb/sim_bus_fault_status.sv
// Bench for bus_fault_status: a behavioural reference model advanced once
// per clock, compared with rd_valid/rd_data at every falling edge.
module sim_bus_fault_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_done = 1'b0, cyc_is_dma = 1'b0;
    logic        flt_nomap = 1'b0, flt_prot = 1'b0, flt_tmo = 1'b0;
    logic        flt_extbus = 1'b0, flt_size = 1'b0, wdog_evt = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_space = 4'h0;
    logic [31:0] acc_addr = 32'h0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    int m_stat = 0;
    int m_rv = 0;
    int m_rd = 0;
    string req = "R11";

    localparam logic [31:0] RA = 32'h6000_0000;
    localparam logic [3:0]  CS = 4'h2;

    always #10 clk = ~clk;

    bus_fault_status u0 (
        .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done), .cyc_is_dma(cyc_is_dma),
        .flt_nomap(flt_nomap), .flt_prot(flt_prot), .flt_tmo(flt_tmo),
        .flt_extbus(flt_extbus), .flt_size(flt_size), .wdog_evt(wdog_evt),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_space(acc_space),
        .acc_addr(acc_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // One clock: compare the previous cycle's result, drive, then advance the model.
    // f = {nomap, prot, tmo, extbus, size}
    task automatic step(input logic rs, input logic dn, input logic dma, input logic [4:0] f,
                        input logic wd, input logic av, input logic wr,
                        input logic [3:0] sp, input logic [31:0] ad);
        int mask;
        bit sel;
        @(negedge clk);
        checks++;
        if (rd_valid !== m_rv[0] || rd_data !== 32'(m_rd)) begin
            errors++;
            $display("FAIL %s: rd_valid=%0b rd_data=%08h expected rd_valid=%0b rd_data=%08h",
                     req, rd_valid, rd_data, m_rv[0], 32'(m_rd));
        end
        rst_n = rs; cyc_done = dn; cyc_is_dma = dma;
        {flt_nomap, flt_prot, flt_tmo, flt_extbus, flt_size} = f;
        wdog_evt = wd; acc_valid = av; acc_write = wr; acc_space = sp; acc_addr = ad;
        @(posedge clk);
        sel = av && !wr && sp == CS && ad == RA;
        mask = 0;
        if (dn && !dma) begin
            if (f[4]) mask += 'h80;
            if (f[3] && !f[4]) mask += 'h40;
            if (f[2]) mask += 'h20;
            if (f[1]) mask += 'h10;
            if (f[0]) mask += 'h02;
        end
        if (!rs) begin
            m_stat = 0; m_rv = 0; m_rd = 0;
        end else begin
            m_rv = sel ? 1 : 0;
            m_rd = sel ? m_stat : 0;
            if (wd) m_stat = 1;
            else m_stat = (sel ? 0 : m_stat) | mask;
        end
    endtask

    task automatic idle();
        step(1, 0, 0, 5'b0, 0, 0, 0, 4'h0, 32'h0);
    endtask
    task automatic fault(input logic dma, input logic [4:0] f);
        step(1, 1, dma, f, 0, 0, 0, 4'h0, 32'h0);
    endtask
    task automatic rd();
        step(1, 0, 0, 5'b0, 0, 1, 0, CS, RA);
    endtask
    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        step(0, 0, 0, 5'b0, 0, 0, 0, 4'h0, 32'h0);
        step(0, 0, 0, 5'b0, 0, 0, 0, 4'h0, 32'h0);
        // R11: reset state read as zero
        req = "R11"; idle(); rd(); idle();
        // R1 / R10: each bit alone lands in its own position
        req = "R1";
        for (int i = 0; i < 5; i++) begin
            fault(0, 5'(1 << i)); rd(); idle();
        end
        // R2: accumulation over several prefetch faults
        req = "R2"; fault(0, 5'b10000); fault(0, 5'b00100); fault(0, 5'b00001); rd(); idle();
        fault(0, 5'b00010); fault(0, 5'b00010); rd(); rd(); idle();
        // R3: DMA cycles ignored
        req = "R3"; fault(1, 5'b11111); rd(); idle();
        fault(0, 5'b00100); fault(1, 5'b10011); rd(); idle();
        // R4: protection qualified by mapping
        req = "R4"; fault(0, 5'b11000); rd(); fault(0, 5'b01000); rd(); idle();
        // R5: writes ignored
        req = "R5"; fault(0, 5'b00010);
        step(1, 0, 0, 5'b0, 0, 1, 1, CS, RA); idle(); rd(); idle();
        // R6: wrong space / wrong address do not select or clear
        req = "R6"; fault(0, 5'b00100);
        step(1, 0, 0, 5'b0, 0, 1, 0, 4'h3, RA);
        step(1, 0, 0, 5'b0, 0, 1, 0, CS, RA + 32'h4);
        step(1, 0, 0, 5'b0, 0, 0, 0, CS, RA);
        rd(); idle();
        // R7: read collides with a new fault
        req = "R7"; fault(0, 5'b10000);
        step(1, 1, 0, 5'b00101, 0, 1, 0, CS, RA); rd(); idle();
        // R9: indicators without the strobe
        req = "R9"; step(1, 0, 0, 5'b11111, 0, 0, 0, 4'h0, 32'h0); rd(); idle();
        // R8: watchdog overrides fault and read; system reset clears bit 0
        req = "R8"; fault(0, 5'b10110);
        step(1, 1, 0, 5'b00011, 1, 1, 0, CS, RA); rd(); idle();
        step(1, 0, 0, 5'b0, 1, 0, 0, 4'h0, 32'h0);
        step(0, 0, 0, 5'b0, 0, 0, 0, 4'h0, 32'h0); rd(); idle();
        // R10: back-to-back reads and zero extension
        req = "R10"; fault(0, 5'b11111); rd(); rd(); idle(); idle();
        summary();
    end
endmodule